// File: doc/BRIEF.md
# Branch and jump resolution unit

This block settles control transfer for one instruction in a single-cycle integer pipeline. From a two-bit jump kind, the two register operands and the instruction's three-bit funct3 field, it reports whether the next program counter leaves the sequential path. It also reports which base the target offset is added to: the current PC, or the first register operand.

The block is purely combinational and has no clock. A separate adder forms the target from the chosen base and the offset. The next-PC multiplexer then uses the taken flag to pick between that target and PC+4. Unconditional jumps always report taken. A conditional branch reports taken only when the comparison selected by funct3 holds. Signed or unsigned interpretation is decided by funct3 alone.

Top module: `bru_resolve`

## Requirements
- R1: When the jump kind is 0 (no transfer), base_pc_o, base_rs1_o and take_o are all 0.
- R2: When the jump kind is 1 (direct jump), base_pc_o and take_o are 1 and base_rs1_o is 0.
- R3: When the jump kind is 2 (register-indirect jump), base_rs1_o and take_o are 1 and base_pc_o is 0.
- R4: When the jump kind is 3 (conditional branch), base_pc_o is 1 and base_rs1_o is 0 whether or not the branch is taken.
- R5: For a branch, funct3 000 takes the branch when the operands are equal, and funct3 001 takes it when they differ.
- R6: For a branch, funct3 100 takes the branch when operand 1 is less than operand 2 as signed two's-complement values, and funct3 101 takes it when operand 1 is greater than or equal to operand 2 as signed values.
- R7: For a branch, funct3 110 takes the branch when operand 1 is less than operand 2 as unsigned values, and funct3 111 takes it when operand 1 is greater than or equal to operand 2 as unsigned values.
- R8: For a branch, the reserved funct3 values 010 and 011 give take_o = 0 for any operands.
- R9: For a branch with equal operands, funct3 101 and 111 are taken, and funct3 100 and 110 are not.
- R10: With operand 1 at the most negative signed value and operand 2 at the most positive, funct3 100 is taken and funct3 110 is not. With the operands swapped, funct3 110 is taken and funct3 100 is not.
- R11: For jump kinds 1 and 2, funct3 and the operand values have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 2 | Jump kind: 0 none, 1 direct jump, 2 register-indirect jump, 3 conditional branch |
| rs1_val_i | input | XLEN (64) | First register operand |
| rs2_val_i | input | XLEN (64) | Second register operand |
| funct3_i | input | 3 | funct3 field of the instruction |
| base_pc_o | output | 1 | Target is PC plus offset |
| base_rs1_o | output | 1 | Target is operand 1 plus offset |
| take_o | output | 1 | Control leaves the sequential path |

## Verification
Every output is due in the same cycle as the input pattern that causes it, because no register lies between the input and output ports. The bench drives each pattern on the falling edge of its pacing clock. It samples the three flags a quarter period later, after the logic has settled and before the next rising edge. Each check therefore covers exactly one input pattern and never one carried over from the pattern before.

// File: rtl/bru_pkg.sv
// Shared encodings for the branch and jump resolution unit.
// Assumes the jump kind is produced by the main decoder with the values below.
package bru_pkg;

    typedef enum logic [1:0] {
        JK_NONE   = 2'd0,
        JK_DIRECT = 2'd1,
        JK_INDIR  = 2'd2,
        JK_COND   = 2'd3
    } jump_kind_e;

    localparam logic [2:0] F3_EQ  = 3'b000;
    localparam logic [2:0] F3_NE  = 3'b001;
    localparam logic [2:0] F3_LT  = 3'b100;
    localparam logic [2:0] F3_GE  = 3'b101;
    localparam logic [2:0] F3_LTU = 3'b110;
    localparam logic [2:0] F3_GEU = 3'b111;

    // Raw relations between the two operands, shared by the selector.
    typedef struct packed {
        logic same;
        logic below_s;
        logic below_u;
    } rel_t;

endpackage

// File: rtl/bru_compare.sv
// Operand comparator: produces equality and signed/unsigned less-than.
// Assumes operands are XLEN-bit two's-complement words; purely combinational.
module bru_compare #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    output bru_pkg::rel_t   rel_o
);
    localparam int MSB = XLEN - 1;

    logic sign_diff;

    // Derive the three relations; signed order differs only when signs differ.
    always_comb begin
        sign_diff     = op_a_i[MSB] ^ op_b_i[MSB];
        rel_o.same    = (op_a_i == op_b_i);
        rel_o.below_u = (op_a_i < op_b_i);
        rel_o.below_s = sign_diff ? op_a_i[MSB] : rel_o.below_u;
    end
endmodule

// File: rtl/bru_cond_select.sv
// Branch condition selector: picks one relation (or its inverse) by funct3.
// Assumes reserved funct3 codes must never produce a taken branch.
module bru_cond_select (
    input  logic [2:0]    funct3_i,
    input  bru_pkg::rel_t rel_i,
    output logic          cond_o
);
    import bru_pkg::*;

    // Map funct3 to the tested condition; unlisted codes give false.
    always_comb begin
        case (funct3_i)
            F3_EQ:   cond_o = rel_i.same;
            F3_NE:   cond_o = ~rel_i.same;
            F3_LT:   cond_o = rel_i.below_s;
            F3_GE:   cond_o = ~rel_i.below_s;
            F3_LTU:  cond_o = rel_i.below_u;
            F3_GEU:  cond_o = ~rel_i.below_u;
            default: cond_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_kind_decode.sv
// Kind decoder: turns the jump kind and branch condition into the three flags.
// Assumes the target base is chosen from the kind alone, independent of outcome.
module bru_kind_decode (
    input  logic [1:0] kind_i,
    input  logic       cond_i,
    output logic       base_pc_o,
    output logic       base_rs1_o,
    output logic       take_o
);
    import bru_pkg::*;

    jump_kind_e kind;

    // Decode the kind into base selection and the taken decision.
    always_comb begin
        kind       = jump_kind_e'(kind_i);
        base_pc_o  = 1'b0;
        base_rs1_o = 1'b0;
        take_o     = 1'b0;
        case (kind)
            JK_DIRECT: begin
                base_pc_o = 1'b1;
                take_o    = 1'b1;
            end
            JK_INDIR: begin
                base_rs1_o = 1'b1;
                take_o     = 1'b1;
            end
            JK_COND: begin
                base_pc_o = 1'b1;
                take_o    = cond_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bru_resolve.sv
// Branch and jump resolution unit (top).
// Decides whether control transfers and which base the target offset adds to.
// Assumes the target adder and next-PC multiplexer sit outside; no state held.
module bru_resolve #(
    parameter int XLEN = 64
) (
    input  logic [1:0]      kind_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [XLEN-1:0] rs2_val_i,
    input  logic [2:0]      funct3_i,
    output logic            base_pc_o,
    output logic            base_rs1_o,
    output logic            take_o
);
    bru_pkg::rel_t rel;
    logic          cond;

    bru_compare #(.XLEN(XLEN)) cmp_i (
        .op_a_i (rs1_val_i),
        .op_b_i (rs2_val_i),
        .rel_o  (rel)
    );

    bru_cond_select sel_i (
        .funct3_i (funct3_i),
        .rel_i    (rel),
        .cond_o   (cond)
    );

    bru_kind_decode dec_i (
        .kind_i     (kind_i),
        .cond_i     (cond),
        .base_pc_o  (base_pc_o),
        .base_rs1_o (base_rs1_o),
        .take_o     (take_o)
    );
endmodule

// File: rtl/bru_resolve_chk.sv
// Port-level checker for bru_resolve; immediate assertions on settled values.
// Assumes the unit is combinational, so every relation holds in the same step.
module bru_resolve_chk #(
    parameter int XLEN = 64
) (
    input logic [1:0]      kind_i,
    input logic [XLEN-1:0] rs1_val_i,
    input logic [XLEN-1:0] rs2_val_i,
    input logic [2:0]      funct3_i,
    input logic            base_pc_o,
    input logic            base_rs1_o,
    input logic            take_o
);
    // Relate the outputs to the inputs whenever anything changes.
    always_comb begin
        a_r1_idle_quiet: assert (kind_i != 2'd0 || !(base_pc_o || base_rs1_o || take_o));
        a_r2_r3_one_base: assert (!(base_pc_o && base_rs1_o));
        a_r11_jump_taken: assert (!(kind_i == 2'd1 || kind_i == 2'd2) || take_o);
        a_r4_branch_pc_base: assert (kind_i != 2'd3 || (base_pc_o && !base_rs1_o));
        a_r8_reserved_not_taken: assert (!(kind_i == 2'd3 && funct3_i[2:1] == 2'b01) || !take_o);
        a_r9_equal_operands: assert (!(kind_i == 2'd3 && rs1_val_i == rs2_val_i
                                       && funct3_i[2] && !funct3_i[1])
                                     || (take_o == funct3_i[0]));
    end
endmodule

bind bru_resolve bru_resolve_chk #(.XLEN(XLEN)) chk_i (
    .kind_i     (kind_i),
    .rs1_val_i  (rs1_val_i),
    .rs2_val_i  (rs2_val_i),
    .funct3_i   (funct3_i),
    .base_pc_o  (base_pc_o),
    .base_rs1_o (base_rs1_o),
    .take_o     (take_o)
);

// File: tb/bru_resolve_tb_top.sv
// Directed bench for bru_resolve: one task per scenario, each checking itself.
module bru_resolve_tb_top;
    localparam int XLEN = 64;
    localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};
    localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]      kind = '0;
    logic [XLEN-1:0] a = '0;
    logic [XLEN-1:0] b = '0;
    logic [2:0]      f3 = '0;
    logic            base_pc, base_rs1, take;
    int              n_chk = 0;
    int              n_bad = 0;
    bit              done = 1'b0;

    always #10 clk = ~clk; // 50 MHz pacing clock

    bru_resolve #(.XLEN(XLEN)) dut_i (
        .kind_i     (kind),
        .rs1_val_i  (a),
        .rs2_val_i  (b),
        .funct3_i   (f3),
        .base_pc_o  (base_pc),
        .base_rs1_o (base_rs1),
        .take_o     (take)
    );

    // Requirement model of the branch outcome, written from R5-style rules.
    function automatic logic model_cond(input logic [2:0] fn,
                                        input logic [XLEN-1:0] x,
                                        input logic [XLEN-1:0] y);
        case (fn)
            3'b000:  return x == y;
            3'b001:  return x != y;
            3'b100:  return $signed(x) <  $signed(y);
            3'b101:  return $signed(x) >= $signed(y);
            3'b110:  return x <  y;
            3'b111:  return x >= y;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic [1:0] k, input logic [2:0] fn,
                         input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
        @(negedge clk);
        kind = k; f3 = fn; a = x; b = y;
        #5;
    endtask

    task automatic check3(input string tag, input logic [2:0] exp);
        n_chk++;
        if ({base_pc, base_rs1, take} !== exp) begin
            n_bad++;
            $display("FAIL %s kind=%0d f3=%b a=%h b=%h got pc/rs1/take=%b expected=%b",
                     tag, kind, f3, a, b, {base_pc, base_rs1, take}, exp);
        end
    endtask

    task automatic t_reset_state();
        #5;
        check3("R1 reset", 3'b000);
    endtask

    task automatic t_r1_none();
        for (int fn = 0; fn < 8; fn++) begin
            drive(2'd0, 3'(fn), SMIN, SMAX);
            check3("R1 none", 3'b000);
        end
    endtask

    task automatic t_r2_r3_r11_jumps();
        for (int fn = 0; fn < 8; fn++) begin
            drive(2'd1, 3'(fn), 64'd7, 64'd3);
            check3("R2 R11 direct", 3'b101);
            drive(2'd2, 3'(fn), 64'd3, 64'd7);
            check3("R3 R11 indirect", 3'b011);
        end
    endtask

    task automatic t_r5_r6_r7_branches();
        logic [XLEN-1:0] xs [7];
        logic [XLEN-1:0] ys [7];
        xs = '{64'd0, SMIN, SMAX, ONES, 64'd0, 64'd5, 64'd1};
        ys = '{64'd0, SMAX, SMIN, 64'd0, ONES, 64'd5, 64'd2};
        for (int p = 0; p < 7; p++) begin
            for (int fn = 0; fn < 8; fn++) begin
                drive(2'd3, 3'(fn), xs[p], ys[p]);
                check3("R4 R5 R6 R7 R8 branch",
                       {1'b1, 1'b0, model_cond(3'(fn), xs[p], ys[p])});
            end
        end
    endtask

    task automatic t_r8_reserved();
        drive(2'd3, 3'b010, 64'd1, 64'd1);
        check3("R8 reserved 010", 3'b100);
        drive(2'd3, 3'b011, 64'd1, 64'd9);
        check3("R8 reserved 011", 3'b100);
    endtask

    task automatic t_r9_equal();
        drive(2'd3, 3'b101, SMIN, SMIN); check3("R9 bge equal", 3'b101);
        drive(2'd3, 3'b111, SMIN, SMIN); check3("R9 bgeu equal", 3'b101);
        drive(2'd3, 3'b100, SMIN, SMIN); check3("R9 blt equal", 3'b100);
        drive(2'd3, 3'b110, SMIN, SMIN); check3("R9 bltu equal", 3'b100);
    endtask

    task automatic t_r10_extremes();
        drive(2'd3, 3'b100, SMIN, SMAX); check3("R10 signed min<max", 3'b101);
        drive(2'd3, 3'b110, SMIN, SMAX); check3("R10 unsigned min<max", 3'b100);
        drive(2'd3, 3'b110, SMAX, SMIN); check3("R10 unsigned max<min", 3'b101);
        drive(2'd3, 3'b100, SMAX, SMIN); check3("R10 signed max<min", 3'b100);
    endtask

    initial begin
        #100000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_r1_none();
        t_r2_r3_r11_jumps();
        t_r5_r6_r7_branches();
        t_r8_reserved();
        t_r9_equal();
        t_r10_extremes();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule